// File: doc/BRIEF.md
# Exception Priority and Return Controller

This block sits beside the fetch stage of a pipelined processor. Each cycle it looks at the pending exception sources and picks exactly one to take. The sources are reset, data abort, software interrupt, illegal instruction, external interrupt and instruction fetch abort. When a source is taken, the block gives the fetch stage a redirect address, which is either the source's vector or the reset address. It also records a return address and a copy of the status register, and it clears the interrupt-enable bit.

An external interrupt is only serviced when the pipeline holds no older instructions. If the pipeline is already empty, the interrupt is taken at once. If it is not, the block first requests a flush and then waits for the flush to report that it has drained. On an exception-return strobe, the block redirects fetch to the saved return address and copies the saved status back into the status register.

Top module: `exc_ctrl`

## Requirements
- R1: An interrupt request is ignored while bit 0 of the status register (the interrupt enable) is 0. In that case no take and no flush request is produced.
- R2: When sources are pending together, only one is taken, in this order from highest to lowest: reset, data abort, software interrupt, illegal instruction, interrupt, fetch abort. The cause codes are 1 reset, 2 data abort, 3 software interrupt, 4 illegal instruction, 5 interrupt, 6 fetch abort, and 0 when nothing is taken.
- R3: The redirect address on a take is the 26-bit vector base followed by a 6-bit offset. The offsets are 0x04 for illegal instruction, 0x08 for software interrupt, 0x0C for interrupt, 0x10 for fetch abort and 0x14 for data abort.
- R4: Taking any exception clears the interrupt-enable bit in the next cycle. A status write in a cycle with no take loads the status register.
- R5: An enabled interrupt with no higher source pending and a non-empty pipeline raises a one-cycle flush request. The interrupt is then taken in the cycle in which the flush-done input is high.
- R6: An enabled interrupt with no higher source pending and an empty pipeline is taken in the same cycle, with no flush request.
- R7: When an interrupt is taken while the stepping input is high, the saved return address is the current PC.
- R8: When an interrupt is taken while running, the saved return address is the branch target if a branch was taken, and PC+4 otherwise.
- R9: Reset, in the same cycle, takes cause 1 and redirects to 0x1000_0000. It then clears the status, the saved status and the return address.
- R10: On a take, the saved status receives the previous status. An exception return that coincides with no take redirects to the saved return address and restores the status from the saved status.
- R11: While an interrupt flush is in progress, a fetch abort is not taken, but a data abort, software interrupt or illegal instruction still is.
- R12: For every source other than the interrupt and reset, the saved return address is the current PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, also taken as the top-priority source |
| data_abort | input | 1 | Data abort pending |
| swi | input | 1 | Software interrupt pending |
| illegal | input | 1 | Illegal instruction pending |
| fetch_abort | input | 1 | Instruction fetch abort pending |
| irq | input | 1 | Level-sensitive interrupt request |
| vector_base | input | 26 | Upper bits of the vector addresses |
| pc | input | 32 | Address of the current instruction |
| branch_taken | input | 1 | The last instruction was a taken branch |
| branch_target | input | 32 | Target of that branch |
| stepping | input | 1 | Core has just resumed from a single step |
| pipe_empty | input | 1 | The pipeline is already drained |
| flush_done | input | 1 | The flush bubble has reached writeback |
| exc_return | input | 1 | Exception-return strobe |
| sr_wr_en | input | 1 | Status register write enable |
| sr_wr_data | input | 8 | Status register write value |
| take_exception | output | 1 | A source is taken this cycle |
| cause | output | 3 | Code of the taken source |
| flush_req | output | 1 | Request a pipeline flush |
| redirect | output | 1 | Load the fetch PC this cycle |
| redirect_pc | output | 32 | Address to load |
| status | output | 8 | Status register |
| saved_status | output | 8 | Status saved at the last take |
| epc | output | 32 | Saved return address |

## Verification
The combinational results are take_exception, cause, flush_req, redirect and redirect_pc. They are due in the same cycle as the inputs that cause them. The bench therefore drives inputs on the falling edge and compares these outputs one time unit later. The registered results are status, saved_status and epc. They are due one rising edge later, so the bench updates its reference state at that edge and compares these outputs at the next falling edge. A flushed interrupt spans several cycles, and the bench follows it with its own flush flag.

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int VB_W = 26,
  parameter int SR_W = 8,
  parameter int IE_BIT = 0,
  parameter logic [VB_W+5:0] RESET_ADDR = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_abort,
  input  logic              swi,
  input  logic              illegal,
  input  logic              fetch_abort,
  input  logic              irq,
  input  logic [VB_W-1:0]   vector_base,
  input  logic [VB_W+5:0]   pc,
  input  logic              branch_taken,
  input  logic [VB_W+5:0]   branch_target,
  input  logic              stepping,
  input  logic              pipe_empty,
  input  logic              flush_done,
  input  logic              exc_return,
  input  logic              sr_wr_en,
  input  logic [SR_W-1:0]   sr_wr_data,
  output logic              take_exception,
  output logic [2:0]        cause,
  output logic              flush_req,
  output logic              redirect,
  output logic [VB_W+5:0]   redirect_pc,
  output logic [SR_W-1:0]   status,
  output logic [SR_W-1:0]   saved_status,
  output logic [VB_W+5:0]   epc
);
  localparam int AW = VB_W + 6;
  localparam logic [2:0] C_NONE = 3'd0, C_RST = 3'd1, C_DABT = 3'd2, C_SWI = 3'd3,
                         C_ILL = 3'd4, C_IRQ = 3'd5, C_FABT = 3'd6;

  logic flushing;
  logic [AW-1:0] vec, ret_addr;

  wire irq_ok   = irq & status[IE_BIT];
  wire higher   = data_abort | swi | illegal;
  wire irq_take = irq_ok & (pipe_empty | (flushing & flush_done));
  wire fa_take  = fetch_abort & ~irq_ok & ~flushing;

  assign flush_req = ~rst & ~higher & irq_ok & ~pipe_empty & ~flushing;

  always_comb begin
    if (rst)              cause = C_RST;
    else if (data_abort)  cause = C_DABT;
    else if (swi)         cause = C_SWI;
    else if (illegal)     cause = C_ILL;
    else if (irq_take)    cause = C_IRQ;
    else if (fa_take)     cause = C_FABT;
    else                  cause = C_NONE;
  end

  assign take_exception = cause != C_NONE;

  always_comb begin
    case (cause)
      C_RST:   vec = RESET_ADDR;
      C_DABT:  vec = {vector_base, 6'h14};
      C_SWI:   vec = {vector_base, 6'h08};
      C_ILL:   vec = {vector_base, 6'h04};
      C_IRQ:   vec = {vector_base, 6'h0c};
      C_FABT:  vec = {vector_base, 6'h10};
      default: vec = '0;
    endcase
  end

  always_comb begin
    if (cause != C_IRQ)   ret_addr = pc;
    else if (stepping)    ret_addr = pc;
    else if (branch_taken) ret_addr = branch_target;
    else                  ret_addr = pc + AW'(4);
  end

  assign redirect    = take_exception | exc_return;
  assign redirect_pc = take_exception ? vec : epc;

  always_ff @(posedge clk) begin
    if (rst) begin
      flushing     <= 1'b0;
      status       <= '0;
      saved_status <= '0;
      epc          <= '0;
    end else if (take_exception) begin
      flushing       <= 1'b0;
      saved_status   <= status;
      status         <= status & ~(SR_W'(1) << IE_BIT);
      epc            <= ret_addr;
    end else begin
      if (exc_return)    status <= saved_status;
      else if (sr_wr_en) status <= sr_wr_data;
      if (flushing && flush_done) flushing <= 1'b0;
      else if (flush_req)         flushing <= 1'b1;
    end
  end

  p_reset_vec_r9: assert property (@(posedge clk)
    rst |-> (cause == C_RST && redirect_pc == RESET_ADDR));
  p_ie_clear_r4: assert property (@(posedge clk) disable iff (rst)
    take_exception |=> !status[IE_BIT]);
  p_flush_once_r5: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> !flush_req);
  p_save_sr_r10: assert property (@(posedge clk) disable iff (rst)
    take_exception |=> saved_status == $past(status));
  p_restore_r10: assert property (@(posedge clk) disable iff (rst)
    (exc_return && !take_exception) |=> status == $past(saved_status));
  p_no_fabt_flush_r11: assert property (@(posedge clk) disable iff (rst)
    flushing |-> cause != C_FABT);
  p_masked_irq_r1: assert property (@(posedge clk) disable iff (rst)
    !status[IE_BIT] |-> (cause != C_IRQ && !flush_req));
endmodule

// File: tb/exc_ctrl_tb_top.sv
module exc_ctrl_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, data_abort, swi, illegal, fetch_abort, irq, branch_taken, stepping;
  logic pipe_empty, flush_done, exc_return, sr_wr_en;
  logic [25:0] vector_base;
  logic [31:0] pc, branch_target;
  logic [7:0] sr_wr_data;
  logic take_exception, flush_req, redirect;
  logic [2:0] cause;
  logic [31:0] redirect_pc, epc;
  logic [7:0] status, saved_status;

  exc_ctrl dut_i (.clk, .rst, .data_abort, .swi, .illegal, .fetch_abort, .irq,
    .vector_base, .pc, .branch_taken, .branch_target, .stepping, .pipe_empty,
    .flush_done, .exc_return, .sr_wr_en, .sr_wr_data, .take_exception, .cause,
    .flush_req, .redirect, .redirect_pc, .status, .saved_status, .epc);

  int checks = 0, errors = 0;
  bit done = 0;
  logic m_fl;
  logic [7:0] m_sr, m_ssr;
  logic [31:0] m_epc;
  logic [2:0] e_cause;
  logic e_flush;
  logic [31:0] e_vec, e_ret;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vec_of(logic [2:0] c);
    case (c)
      3'd1: return 32'h1000_0000;
      3'd2: return {vector_base, 6'h14};
      3'd3: return {vector_base, 6'h08};
      3'd4: return {vector_base, 6'h04};
      3'd5: return {vector_base, 6'h0c};
      3'd6: return {vector_base, 6'h10};
      default: return 32'h0;
    endcase
  endfunction

  task automatic predict();
    logic iok;
    iok = irq & m_sr[0];
    if (rst) e_cause = 1;
    else if (data_abort) e_cause = 2;
    else if (swi) e_cause = 3;
    else if (illegal) e_cause = 4;
    else if (iok && (pipe_empty || (m_fl && flush_done))) e_cause = 5;
    else if (fetch_abort && !iok && !m_fl) e_cause = 6;
    else e_cause = 0;
    e_flush = !rst && !(data_abort | swi | illegal) && iok && !pipe_empty && !m_fl;
    e_vec = vec_of(e_cause);
    if (e_cause == 5) e_ret = stepping ? pc : (branch_taken ? branch_target : pc + 4);
    else e_ret = pc;
  endtask

  task automatic cyc();
    #1;
    predict();
    chk("R2 cause", {29'b0, cause}, {29'b0, e_cause});
    chk("R2 take", {31'b0, take_exception}, {31'b0, e_cause != 0});
    chk("R5 flush_req", {31'b0, flush_req}, {31'b0, e_flush});
    chk("R3 redirect", {31'b0, redirect}, {31'b0, (e_cause != 0) | exc_return});
    chk("R3 redirect_pc", redirect_pc, (e_cause != 0) ? e_vec : m_epc);
    chk("R4 status", {24'b0, status}, {24'b0, m_sr});
    chk("R10 saved_status", {24'b0, saved_status}, {24'b0, m_ssr});
    chk("R12 epc", epc, m_epc);
    @(posedge clk);
    if (rst) begin
      m_fl = 0; m_sr = 0; m_ssr = 0; m_epc = 0;
    end else if (e_cause != 0) begin
      m_fl = 0; m_ssr = m_sr; m_sr = m_sr & 8'hfe; m_epc = e_ret;
    end else begin
      if (exc_return) m_sr = m_ssr;
      else if (sr_wr_en) m_sr = sr_wr_data;
      if (m_fl && flush_done) m_fl = 0;
      else if (e_flush) m_fl = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    rst = 0; data_abort = 0; swi = 0; illegal = 0; fetch_abort = 0; irq = 0;
    branch_taken = 0; stepping = 0; pipe_empty = 0; flush_done = 0;
    exc_return = 0; sr_wr_en = 0; sr_wr_data = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_fl = 0; m_sr = 0; m_ssr = 0; m_epc = 0;
    idle();
    vector_base = 26'h2aa_aaa; pc = 32'h100; branch_target = 32'h800;
    @(negedge clk);
    rst = 1; irq = 1; data_abort = 1;
    #1;
    chk("R9 reset cause", {29'b0, cause}, 32'd1);
    chk("R9 reset vector", redirect_pc, 32'h1000_0000);
    cyc();
    chk("R9 status after reset", {24'b0, status}, 32'h0);
    idle(); irq = 1; pipe_empty = 1;
    #1; chk("R1 masked irq", {31'b0, take_exception | flush_req}, 32'h0);
    cyc();
    idle(); sr_wr_en = 1; sr_wr_data = 8'h01; cyc();
    chk("R4 status written", {24'b0, status}, 32'h1);
    idle(); irq = 1;
    #1; chk("R5 flush requested", {31'b0, flush_req}, 32'h1);
    cyc();
    idle(); irq = 1; fetch_abort = 1;
    #1; chk("R11 fetch abort held off", {29'b0, cause}, 32'h0);
    cyc();
    idle(); irq = 1; flush_done = 1; pc = 32'h100;
    #1; chk("R5 irq after flush", {29'b0, cause}, 32'd5);
    cyc();
    chk("R8 epc pc+4", epc, 32'h104);
    chk("R4 ie cleared", {31'b0, status[0]}, 32'h0);
    chk("R10 saved status", {24'b0, saved_status}, 32'h1);
    idle(); exc_return = 1;
    #1; chk("R10 return target", redirect_pc, 32'h104);
    cyc();
    chk("R10 status restored", {24'b0, status}, 32'h1);
    idle(); irq = 1; pipe_empty = 1; stepping = 1; pc = 32'h200;
    #1; chk("R6 immediate irq", {29'b0, cause}, 32'd5);
    chk("R6 no flush", {31'b0, flush_req}, 32'h0);
    cyc();
    chk("R7 epc current pc", epc, 32'h200);
    idle(); illegal = 1; fetch_abort = 1; pc = 32'h300; cyc();
    chk("R12 epc faulting pc", epc, 32'h300);
    void'($urandom(32'd12345));
    for (int i = 0; i < 4000; i++) begin
      rst = ($urandom % 200) == 0;
      data_abort = ($urandom % 16) == 0;
      swi = ($urandom % 16) == 0;
      illegal = ($urandom % 16) == 0;
      fetch_abort = ($urandom % 8) == 0;
      irq = $urandom % 2;
      pipe_empty = ($urandom % 4) == 0;
      flush_done = ($urandom % 3) == 0;
      stepping = $urandom % 2;
      branch_taken = $urandom % 2;
      pc = {$urandom, 2'b00};
      branch_target = {$urandom, 2'b00};
      vector_base = 26'($urandom);
      exc_return = ($urandom % 16) == 0;
      sr_wr_en = ($urandom % 6) == 0;
      sr_wr_data = 8'($urandom);
      cyc();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule